// File: doc/BRIEF.md
# Memory-Mapped ATA Task-File Decoder

This block sits on the card side of a 2 KB common-memory window. It turns host memory cycles into task-file register accesses or into sequential transfers through a data port. The inputs are eleven address lines, two active-low byte-lane enables (`ce1_n` for the low/even lane, `ce2_n` for the high/odd lane), and active-low read (`oe_n`) and write (`we_n`) strobes. All inputs are synchronous to `clk`. Each access is latched when its strobe is asserted and takes effect once, on the clock edge that first sees the strobe released.

The data register has several aliases. It answers at offsets 0, 8 and 9 of the lower kilobyte, and at every address of the upper kilobyte, which acts as a block-move window. All of these aliases feed one internal 512-byte buffer through a byte pointer. The pointer enforces even-then-odd byte ordering and whole-word ordering. Task-file registers are held outside the block. The block presents a register select, a one-cycle read or write pulse and a write byte to them, and it forwards their read byte onto the proper lane.

The controller has three states. `S_IDLE` waits. It moves to `S_READ` when `oe_n` falls, or to `S_WRITE` when only `we_n` falls, and it latches the decode at that moment. `S_READ` returns to `S_IDLE` when `oe_n` is seen high. `S_WRITE` returns to `S_IDLE` when `we_n` is seen high. Either return transition is the commit, when the pointer moves, the buffer is written and the task-file pulse is raised on the next cycle.

Top module: `ata_mmio_decoder`

## Requirements
- R1: After reset the controller is in `S_IDLE`, `dout_en`, `tf_rd` and `tf_wr` are 0, and the buffer pointer is 0.
- R2: A word access (both enables low) at offset 0, 8 or 9 moves bytes p and p+1, with byte p on `dout[7:0]`/`din[7:0]`. The pointer then advances by 2, so repeated word accesses walk consecutive words.
- R3: A byte access at offset 0 or 8 with only `ce1_n` low moves the byte at the pointer on the low lane and advances the pointer by 1, so repeated accesses give even then odd bytes.
- R4: An access at offset 9 with one enable low moves only the odd byte of the current word (byte p|1) on the enabled lane, and leaves the pointer at (p|1)+1. Alternating offset 8 then 9 byte accesses therefore walk consecutive bytes.
- R5: A byte access at offset 0 with only `ce2_n` low reaches task-file register 1 (error on read, feature on write) on `dout[15:8]`/`din[15:8]`, and leaves the data pointer unchanged.
- R6: With `addr[10]`=0, the offset is `addr[3:0]` and `addr[9:4]` are ignored. Offsets 1–7, 14 and 15 select task-file register `tf_sel` equal to the offset, and offset 13 selects 1. Offsets 10–12 reach nothing and read as zero. A write to offset 15 raises no `tf_wr`. A task-file byte appears on the high lane only when just `ce2_n` is low, and on the low lane otherwise.
- R7: With `addr[10]`=1, an even address behaves as offset 8 and an odd address as offset 9, whatever `addr[9:1]` hold.
- R8: Each strobe completes exactly one access. `tf_rd` or `tf_wr` is a single-cycle pulse on the cycle after the commit edge, with `tf_sel` and `tf_wdata` valid during it.
- R9: `dout_en` is 1 only in `S_READ` with at least one enable low at strobe start. It is 0 on the cycle after the release of `oe_n` is seen. The unused lane of a byte read carries zero.
- R10: A word access made while the pointer is odd first rounds the pointer up to the next even byte, and leaves it at that even byte plus 2.
- R11: A `new_xfer` pulse returns the pointer to 0 and takes precedence over a commit on the same edge.
- R12: The pointer wraps from 511 to 0, so 256 word accesses bring it back to the first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 11 | Window address A10..A0 |
| ce1_n | input | 1 | Low-lane (even byte) enable, active low |
| ce2_n | input | 1 | High-lane (odd byte) enable, active low |
| oe_n | input | 1 | Read strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| din | input | 16 | Host write data |
| dout | output | 16 | Read data toward the host |
| dout_en | output | 1 | Drive enable for `dout` |
| new_xfer | input | 1 | Start of a new sector transfer; clears the pointer |
| tf_sel | output | 4 | Selected task-file register |
| tf_rd | output | 1 | One-cycle task-file read pulse |
| tf_wr | output | 1 | One-cycle task-file write pulse |
| tf_wdata | output | 8 | Byte written to the task-file register |
| tf_rdata | input | 8 | Byte read from the selected task-file register |

## Verification
The assertions assume that the strobes are synchronous to `clk` and that each one stays low for at least one full cycle. They also assume that address, enables and write data hold steady for the whole strobe, and that reads and writes do not overlap. The bench drives each access from the falling clock edge as a fixed five-phase sequence: setup with the strobe low, hold, sample, release, and settle. This keeps every strobe at two cycles and leaves idle cycles between accesses. Repeated byte accesses to offset 9 alone are never issued as an ordering test. The bench only uses them after an even-aligned pointer, where R4 defines the result.

// File: rtl/ata_mmio_pkg.sv
package ata_mmio_pkg;

    typedef enum logic [2:0] {
        K_NONE,
        K_WORD,
        K_BYTE,
        K_ODD,
        K_TASK
    } acc_kind_t;

    typedef enum logic [1:0] {
        S_IDLE,
        S_READ,
        S_WRITE
    } ctl_state_t;

    typedef struct packed {
        acc_kind_t  kind;
        logic [3:0] tfr;
        logic       hi;
    } dec_t;

    localparam logic [3:0] TF_RESERVED_WR = 4'hF;

endpackage

// File: rtl/ata_mmio_addr_dec.sv
module ata_mmio_addr_dec
    import ata_mmio_pkg::*;
#(
    parameter int AW = 11
) (
    input  logic [AW-1:0] addr,
    input  logic          ce1_n,
    input  logic          ce2_n,
    output dec_t          dec
);
    localparam int WIN_BIT = AW - 1;

    logic [3:0] off;
    logic       both, low_only, high_only;
    logic       unused_mid;

    assign unused_mid = ^addr[WIN_BIT-1:4];
    assign off        = addr[WIN_BIT] ? {3'b100, addr[0]} : addr[3:0];
    assign both       = !ce1_n && !ce2_n;
    assign low_only   = !ce1_n && ce2_n;
    assign high_only  = ce1_n && !ce2_n;

    always_comb begin
        dec = '{kind: K_NONE, tfr: off, hi: high_only};
        unique case (off)
            4'h0: begin
                if (both)           dec.kind = K_WORD;
                else if (low_only)  dec.kind = K_BYTE;
                else if (high_only) begin
                    dec.kind = K_TASK;
                    dec.tfr  = 4'h1;
                end
            end
            4'h8: begin
                if (both)          dec.kind = K_WORD;
                else if (low_only) dec.kind = K_BYTE;
            end
            4'h9: begin
                if (both)                       dec.kind = K_WORD;
                else if (low_only || high_only) dec.kind = K_ODD;
            end
            4'hA, 4'hB, 4'hC: dec.kind = K_NONE;
            4'hD: begin
                if (!ce1_n || !ce2_n) dec.kind = K_TASK;
                dec.tfr = 4'h1;
            end
            default: begin
                if (!ce1_n || !ce2_n) dec.kind = K_TASK;
            end
        endcase
    end

    always_comb begin
        if (addr[WIN_BIT]) begin
            assert_window_alias_R7: assert (dec.kind != K_TASK);
        end
    end

endmodule

// File: rtl/ata_mmio_data_port.sv
module ata_mmio_data_port
    import ata_mmio_pkg::*;
#(
    parameter int BUF_BYTES = 512
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        new_xfer,
    input  logic        commit,
    input  logic        is_write,
    input  acc_kind_t   kind,
    input  logic        hi,
    input  logic [15:0] wdata,
    output logic [15:0] rdata
);
    localparam int PW = $clog2(BUF_BYTES);

    logic [7:0]    mem [BUF_BYTES];
    logic [PW-1:0] ptr, al, al1, podd, ptr_nxt;
    logic [7:0]    wbyte, rbyte;
    logic          data_kind;

    assign al        = ptr + {{(PW-1){1'b0}}, ptr[0]};
    assign al1       = al + 1'b1;
    assign podd      = ptr | {{(PW-1){1'b0}}, 1'b1};
    assign wbyte     = hi ? wdata[15:8] : wdata[7:0];
    assign data_kind = (kind == K_WORD) || (kind == K_BYTE) || (kind == K_ODD);

    always_comb begin
        unique case (kind)
            K_WORD:  ptr_nxt = al + 2'd2;
            K_BYTE:  ptr_nxt = ptr + 1'b1;
            K_ODD:   ptr_nxt = podd + 1'b1;
            default: ptr_nxt = ptr;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     ptr <= '0;
        else if (new_xfer)              ptr <= '0;
        else if (commit && data_kind)   ptr <= ptr_nxt;
    end

    always_ff @(posedge clk) begin
        if (commit && is_write) begin
            unique case (kind)
                K_WORD: begin
                    mem[al]  <= wdata[7:0];
                    mem[al1] <= wdata[15:8];
                end
                K_BYTE:  mem[ptr]  <= wbyte;
                K_ODD:   mem[podd] <= wbyte;
                default: ;
            endcase
        end
    end

    assign rbyte = (kind == K_ODD) ? mem[podd] : mem[ptr];

    always_comb begin
        unique case (kind)
            K_WORD:         rdata = {mem[al1], mem[al]};
            K_BYTE, K_ODD:  rdata = hi ? {rbyte, 8'h00} : {8'h00, rbyte};
            default:        rdata = 16'h0000;
        endcase
    end

    assert_word_even_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && kind == K_WORD && !new_xfer) |=> !ptr[0]);

    assert_odd_lands_even_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && kind == K_ODD && !new_xfer) |=> !ptr[0]);

    assert_byte_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && kind == K_BYTE && !new_xfer) |=> (ptr == $past(ptr) + 1'b1));

    assert_xfer_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        new_xfer |=> (ptr == '0));

endmodule

// File: rtl/ata_mmio_decoder.sv
module ata_mmio_decoder
    import ata_mmio_pkg::*;
#(
    parameter int AW        = 11,
    parameter int BUF_BYTES = 512
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          ce1_n,
    input  logic          ce2_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic [15:0]   din,
    output logic [15:0]   dout,
    output logic          dout_en,
    input  logic          new_xfer,
    output logic [3:0]    tf_sel,
    output logic          tf_rd,
    output logic          tf_wr,
    output logic [7:0]    tf_wdata,
    input  logic [7:0]    tf_rdata
);
    ctl_state_t  state, state_nxt;
    dec_t        dec_now, dec_q;
    logic        any_q;
    logic [15:0] wdat_q, port_rdata;
    logic        commit, is_write, start;
    logic        rd_pulse_q, wr_pulse_q;

    ata_mmio_addr_dec #(.AW(AW)) u_dec (
        .addr  (addr),
        .ce1_n (ce1_n),
        .ce2_n (ce2_n),
        .dec   (dec_now)
    );

    ata_mmio_data_port #(.BUF_BYTES(BUF_BYTES)) u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .new_xfer (new_xfer),
        .commit   (commit),
        .is_write (is_write),
        .kind     (dec_q.kind),
        .hi       (dec_q.hi),
        .wdata    (wdat_q),
        .rdata    (port_rdata)
    );

    always_comb begin
        state_nxt = state;
        unique case (state)
            S_IDLE:  if (!oe_n) state_nxt = S_READ;
                     else if (!we_n) state_nxt = S_WRITE;
            S_READ:  if (oe_n) state_nxt = S_IDLE;
            S_WRITE: if (we_n) state_nxt = S_IDLE;
            default: state_nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nxt;
    end

    assign start    = (state == S_IDLE) && (state_nxt != S_IDLE);
    assign is_write = (state == S_WRITE);
    assign commit   = ((state == S_READ) && oe_n) || ((state == S_WRITE) && we_n);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_q      <= '{kind: K_NONE, tfr: 4'h0, hi: 1'b0};
            any_q      <= 1'b0;
            wdat_q     <= '0;
            rd_pulse_q <= 1'b0;
            wr_pulse_q <= 1'b0;
        end else begin
            if (start) begin
                dec_q <= dec_now;
                any_q <= !ce1_n || !ce2_n;
            end
            if (!we_n) wdat_q <= din;
            rd_pulse_q <= commit && !is_write && (dec_q.kind == K_TASK);
            wr_pulse_q <= commit && is_write && (dec_q.kind == K_TASK)
                          && (dec_q.tfr != TF_RESERVED_WR);
        end
    end

    always_comb begin
        dout_en  = (state == S_READ) && any_q;
        tf_sel   = dec_q.tfr;
        tf_rd    = rd_pulse_q;
        tf_wr    = wr_pulse_q;
        tf_wdata = dec_q.hi ? wdat_q[15:8] : wdat_q[7:0];
        dout     = 16'h0000;
        if (dout_en) begin
            if (dec_q.kind == K_TASK)
                dout = dec_q.hi ? {tf_rdata, 8'h00} : {8'h00, tf_rdata};
            else
                dout = port_rdata;
        end
    end

    assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tf_rd || tf_wr) |=> !(tf_rd || tf_wr));

    assert_wr_from_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tf_wr |-> ($past(state) == S_WRITE));

    assert_no_reserved_wr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tf_wr |-> (tf_sel != TF_RESERVED_WR));

    assert_bus_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == S_READ) && oe_n) |=> !dout_en);

    assert_pulse_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tf_rd, tf_wr}));

endmodule

// File: tb/ata_mmio_decoder_tb.sv
module ata_mmio_decoder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] addr = '0;
    logic        ce1_n = 1'b1, ce2_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [15:0] din = '0;
    logic [15:0] dout;
    logic        dout_en;
    logic        new_xfer = 1'b0;
    logic [3:0]  tf_sel;
    logic        tf_rd, tf_wr;
    logic [7:0]  tf_wdata, tf_rdata;

    int nchk = 0, nfail = 0;
    int rd_cnt = 0, wr_cnt = 0;
    logic [3:0] last_sel;
    logic [7:0] last_wd;
    logic [7:0] refm [512];
    int ptr = 0;
    logic [15:0] got;
    logic        den, den_after;

    always #5 clk = ~clk;

    assign tf_rdata = {4'hA, tf_sel};

    ata_mmio_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ce1_n(ce1_n), .ce2_n(ce2_n),
        .oe_n(oe_n), .we_n(we_n), .din(din), .dout(dout), .dout_en(dout_en),
        .new_xfer(new_xfer), .tf_sel(tf_sel), .tf_rd(tf_rd), .tf_wr(tf_wr),
        .tf_wdata(tf_wdata), .tf_rdata(tf_rdata)
    );

    always @(posedge clk) begin
        if (rst_n) begin
            if (tf_rd) rd_cnt <= rd_cnt + 1;
            if (tf_wr) begin
                wr_cnt   <= wr_cnt + 1;
                last_sel <= tf_sel;
                last_wd  <= tf_wdata;
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s got %h exp %h", req, act, exp);
        end
    endtask

    task automatic access(input bit rd, input logic [10:0] a, input bit c1, input bit c2,
                          input logic [15:0] wd);
        @(negedge clk);
        addr = a; ce1_n = c1; ce2_n = c2; din = wd;
        if (rd) oe_n = 1'b0; else we_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        got = dout; den = dout_en;
        oe_n = 1'b1; we_n = 1'b1;
        @(negedge clk);
        den_after = dout_en;
        ce1_n = 1'b1; ce2_n = 1'b1;
        @(negedge clk);
    endtask

    // Reference: mode 1 word, 2 sequential byte, 3 odd byte
    function automatic logic [15:0] model(input int mode, input bit hi, input logic [15:0] wd, input bit wr);
        int al;
        logic [7:0] b;
        logic [15:0] r;
        r = '0;
        if (mode == 1) begin
            al = (ptr + (ptr & 1)) % 512;
            if (wr) begin refm[al] = wd[7:0]; refm[(al+1)%512] = wd[15:8]; end
            r = {refm[(al+1)%512], refm[al]};
            ptr = (al + 2) % 512;
        end else begin
            al = (mode == 3) ? (ptr | 1) : ptr;
            if (wr) refm[al] = hi ? wd[15:8] : wd[7:0];
            b = refm[al];
            r = hi ? {b, 8'h00} : {8'h00, b};
            ptr = (al + 1) % 512;
        end
        return r;
    endfunction

    task automatic data_rd(input int mode, input logic [10:0] a, input bit c1, input bit c2, input string req);
        logic [15:0] e;
        e = model(mode, c1 && !c2, 16'h0, 1'b0);
        access(1'b1, a, c1, c2, 16'h0);
        check(got === e && den === 1'b1, req, got, e);
    endtask

    task automatic pulse_xfer();
        @(negedge clk); new_xfer = 1'b1;
        @(negedge clk); new_xfer = 1'b0;
        ptr = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL R8 watchdog got hang exp completion");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        int rc, wc;
        logic [15:0] e;
        logic [3:0] r;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(dout_en === 1'b0 && tf_rd === 1'b0 && tf_wr === 1'b0, "R1 idle outputs", {dout_en, tf_rd, tf_wr}, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(dout_en === 1'b0, "R1 dout_en after reset", {15'h0, dout_en}, 16'h0);

        // Fill buffer with 256 word writes from pointer 0 (R1, R12)
        for (int i = 0; i < 256; i++) begin
            e = {8'((2*i+1)*37 + 11), 8'((2*i)*37 + 11)};
            void'(model(1, 1'b0, e, 1'b1));
            access(1'b0, 11'h000, 1'b0, 1'b0, e);
        end
        check(ptr == 0, "R12 model wrap", 16'(ptr), 16'h0);
        // R12/R1: pointer wrapped to byte 0 without new_xfer
        data_rd(1, 11'h000, 1'b0, 1'b0, "R12 wrap word read");
        data_rd(1, 11'h000, 1'b0, 1'b0, "R2 word offset 0");
        data_rd(1, 11'h008, 1'b0, 1'b0, "R2 word offset 8");
        data_rd(1, 11'h009, 1'b0, 1'b0, "R2 word offset 9");
        data_rd(1, 11'h3F0, 1'b0, 1'b0, "R6 word offset 0 upper bits ignored");

        // R11
        pulse_xfer();
        data_rd(1, 11'h000, 1'b0, 1'b0, "R11 first word after new_xfer");

        // R3: sequential byte reads, low lane, zero high lane (R9)
        for (int i = 0; i < 6; i++)
            data_rd(2, (i % 2) ? 11'h008 : 11'h000, 1'b0, 1'b1, "R3 byte sequence");

        // R4: alternating 8 then 9
        for (int i = 0; i < 4; i++) begin
            data_rd(2, 11'h008, 1'b0, 1'b1, "R4 even byte via offset 8");
            data_rd(3, 11'h009, 1'b0, 1'b1, "R4 odd byte via offset 9");
        end
        // R4: offset 9 on high lane at even pointer moves odd byte only
        data_rd(3, 11'h009, 1'b1, 1'b0, "R4 odd byte high lane");

        // R7: window sweep
        for (int i = 0; i < 16; i++) begin
            logic [10:0] wa;
            wa = 11'h400 | 11'((i * 97) << 1);
            data_rd(2, wa, 1'b0, 1'b1, "R7 window even address");
            data_rd(3, wa | 11'h001, 1'b0, 1'b1, "R7 window odd address");
            data_rd(1, wa | 11'(i & 1), 1'b0, 1'b0, "R7 window word");
        end

        // R10: odd pointer then word
        data_rd(2, 11'h000, 1'b0, 1'b1, "R10 setup byte");
        check(ptr % 2 == 1, "R10 model odd", 16'(ptr), 16'h1);
        data_rd(1, 11'h000, 1'b0, 1'b0, "R10 realigned word");
        data_rd(1, 11'h008, 1'b0, 1'b0, "R10 following word");

        // R5: odd lane at offset 0 goes to register 1, pointer untouched
        rc = rd_cnt;
        access(1'b1, 11'h000, 1'b1, 1'b0, 16'h0);
        check(got === {8'hA1, 8'h00}, "R5 error on high lane", got, {8'hA1, 8'h00});
        check(rd_cnt == rc + 1, "R5 read pulse", 16'(rd_cnt - rc), 16'h1);
        wc = wr_cnt;
        access(1'b0, 11'h000, 1'b1, 1'b0, 16'h6C00);
        check(wr_cnt == wc + 1 && last_sel == 4'h1 && last_wd == 8'h6C, "R5 feature write",
              {last_sel, 4'h0, last_wd}, 16'h106C);
        data_rd(2, 11'h000, 1'b0, 1'b1, "R5 pointer unchanged");

        // R6/R8/R9: task-file sweep, both lanes, reads then writes
        for (int off = 1; off < 16; off++) begin
            if (off == 8 || off == 9) continue;
            for (int ln = 0; ln < 2; ln++) begin
                logic [10:0] a;
                bit none;
                a = {1'b0, 6'(off * 5 + ln * 19), 4'(off)};
                none = (off >= 10 && off <= 12);
                r = (off == 13) ? 4'h1 : 4'(off);
                e = none ? 16'h0 : (ln ? {4'hA, r, 8'h00} : {8'h00, 4'hA, r});
                rc = rd_cnt;
                access(1'b1, a, ln ? 1'b1 : 1'b0, ln ? 1'b0 : 1'b1, 16'h0);
                check(got === e && den === 1'b1, "R6 task read data", got, e);
                check(den_after === 1'b0, "R9 release after read", {15'h0, den_after}, 16'h0);
                check(rd_cnt == rc + (none ? 0 : 1), "R8 one read pulse", 16'(rd_cnt - rc), 16'(none ? 0 : 1));
                wc = wr_cnt;
                access(1'b0, a, ln ? 1'b1 : 1'b0, ln ? 1'b0 : 1'b1, {8'(8'h50 + off), 8'(8'hC0 + off)});
                if (none || off == 15)
                    check(wr_cnt == wc, "R6 no write pulse", 16'(wr_cnt - wc), 16'h0);
                else
                    check(wr_cnt == wc + 1 && last_sel == r &&
                          last_wd == (ln ? 8'(8'h50 + off) : 8'(8'hC0 + off)),
                          "R8 task write pulse", {last_sel, 4'(wr_cnt - wc), last_wd},
                          {r, 4'h1, (ln ? 8'(8'h50 + off) : 8'(8'hC0 + off))});
            end
        end
        // Pointer untouched by task sweep (R6)
        data_rd(2, 11'h008, 1'b0, 1'b1, "R6 data pointer after sweep");

        // R9: no enables -> bus not driven
        access(1'b1, 11'h000, 1'b1, 1'b1, 16'h0);
        check(den === 1'b0 && got === 16'h0, "R9 no enable no drive", {15'h0, den}, 16'h0);

        // R2/R11: byte write path then read back
        pulse_xfer();
        void'(model(2, 1'b0, 16'h00E7, 1'b1));
        access(1'b0, 11'h000, 1'b0, 1'b1, 16'h00E7);
        void'(model(3, 1'b1, 16'h3C00, 1'b1));
        access(1'b0, 11'h009, 1'b1, 1'b0, 16'h3C00);
        pulse_xfer();
        data_rd(1, 11'h000, 1'b0, 1'b0, "R4 byte writes read as word");

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule